// File: doc/BRIEF.md
# Multi-mode 16-bit PWM timer

This block is a 16-bit timer whose counting scheme is chosen by a 4-bit waveform mode code. The code selects one of several schemes. Plain free-running counting and clear-on-compare counting are the non-PWM schemes. Single-slope fast PWM counts up and wraps. Dual-slope PWM counts up to the limit and then back down. For each code the block also fixes three things: where the count limit (TOP) comes from, the point at which a buffered compare value takes effect, and the point at which the overflow flag is raised. TOP can be a fixed 8-, 9-, 10-bit or full-width value, the active compare A value, or the capture register.

The counter advances only on cycles where the `tick` input is high. That input stands in for an external prescaler. Software-side writes arrive through simple write strobes that share one data bus. There is one strobe for the mode register, one for each of the two compare channels and one for the capture register. Two PWM outputs follow the compare channels. Three sticky flags report overflow and the two compare matches, and each flag is cleared by writing a one.

Top module: `pwm16_timer`

## Requirements
- R1: After a synchronous active-low reset, the count, the mode, both PWM outputs and all three flags are 0.
- R2: The count changes only on cycles with `tick` high. In single-slope modes (0, 4, 5, 6, 7, 12, 14, 15), a tick at a count greater than or equal to TOP loads 0, and any other tick adds 1.
- R3: The mode sets TOP as follows. Mode 0 uses 0xFFFF. Modes 1 and 5 use 0x00FF, modes 2 and 6 use 0x01FF, and modes 3 and 7 use 0x03FF. Modes 4, 9, 11 and 15 use the active compare A value. Modes 8, 10, 12 and 14 use the capture register.
- R4: In dual-slope modes (1, 2, 3, 8, 9, 10, 11) the counter counts up. On the tick at or above TOP it turns down and subtracts 1. It counts down to 0, and on the tick at 0 it turns up and loads 1.
- R5: In modes 0, 4 and 12, a compare write updates the active compare value in the same clock.
- R6: In every other mode, a compare write goes to a shadow register. The shadow is copied to the active value at the update point. In modes 1, 2, 3, 10 and 11 the update point is the tick that turns the count down at TOP. In modes 5, 6, 7, 14 and 15 it is the wrap tick. In modes 8 and 9 it is the tick that turns the count up at 0.
- R7: The overflow flag (clear bit 0) sets after one of three ticks, depending on the mode. In modes 0, 4 and 12 it is the tick at count 0xFFFF. In modes 5, 6, 7, 14 and 15 it is the wrap tick. In dual-slope modes it is the tick that turns the count up at 0.
- R8: A compare flag (A on clear bit 1, B on clear bit 2) sets after a tick on which the count equals that channel's active compare value.
- R9: In fast PWM modes (5, 6, 7, 14, 15) an output goes to 1 after a wrap tick. Otherwise it goes to 0 after a compare-match tick, and the wrap takes priority over the match.
- R10: In dual-slope modes, an output goes to 0 after a match tick while counting up and to 1 after a match tick while counting down.
- R11: In modes 0, 4, 12 and 13 both PWM outputs are 0.
- R12: Mode 13 is reserved. In that mode the count holds and no flag sets.
- R13: Writing a one to a bit of `flag_clr` clears that flag. If a set event occurs in the same cycle, the flag is set instead.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count enable from the prescaler |
| mode_we | input | 1 | Write strobe for the mode register |
| mode_wd | input | 4 | New waveform mode code |
| ocra_we | input | 1 | Write strobe for compare channel A |
| ocrb_we | input | 1 | Write strobe for compare channel B |
| cap_we | input | 1 | Write strobe for the capture register |
| wdata | input | 16 | Shared write data for the compare and capture registers |
| flag_clr | input | 3 | Write-one-to-clear: bit 0 overflow, bit 1 compare A, bit 2 compare B |
| count | output | 16 | Current counter value |
| pwm_a | output | 1 | PWM output of channel A |
| pwm_b | output | 1 | PWM output of channel B |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmpa_flag | output | 1 | Sticky compare A match flag |
| cmpb_flag | output | 1 | Sticky compare B match flag |

## Verification
Every one of the sixteen mode codes is run with a random tick pattern, small random TOP and compare values, and random compare rewrites in mid-period. The single-slope, dual-slope, immediate, buffered and reserved behaviours are therefore each exercised, and the bench can tell an update taken at the wrong point from one taken at the right point. Random flag clears, some of which land on a set event, separate set-over-clear priority from plain clearing. Directed runs at fixed 9-bit TOP, at capture-register TOP, at compare-A TOP in dual slope and at full 16-bit range pin down the limit selection and the overflow-at-maximum point.

// File: rtl/pwm16_pkg.sv
// Shared types for the multi-mode PWM timer.
// Assumes a 4-bit mode code; the counter width is set per instance.
package pwm16_pkg;

    localparam int MODE_W   = 4;
    localparam int NCMP     = 2;
    localparam int NFLAG    = NCMP + 1;
    localparam logic [4:0] FULL_BITS = 5'd31;

    typedef enum logic [1:0] {TOP_FIXED, TOP_CMPA, TOP_CAPT} top_src_e;
    typedef enum logic [1:0] {UPD_NONE, UPD_NOW, UPD_AT_TOP, UPD_AT_BOT} upd_pt_e;
    typedef enum logic [1:0] {OVF_NONE, OVF_AT_MAX, OVF_AT_TOP, OVF_AT_BOT} ovf_pt_e;

    typedef struct packed {
        top_src_e   src;
        logic [4:0] fix_bits;
        upd_pt_e    upd;
        ovf_pt_e    ovf;
        logic       dual;
        logic       fast;
        logic       hold;
    } mode_cfg_t;

endpackage

// File: rtl/pwm16_mode_decode.sv
// Mode table: turns the 4-bit mode code into a configuration record and
// resolves the current TOP value from its source.
// Assumes the compare A input is the active (not shadow) value.
module pwm16_mode_decode
    import pwm16_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [MODE_W-1:0] mode,
    input  logic [CNT_W-1:0]  cmpa_act,
    input  logic [CNT_W-1:0]  capt,
    output mode_cfg_t         cfg,
    output logic [CNT_W-1:0]  top
);

    localparam logic [CNT_W:0] ONE = {{CNT_W{1'b0}}, 1'b1};

    logic [CNT_W:0] fixed_wide;

    // Purpose: table lookup of the per-mode configuration.
    always_comb begin
        cfg = '{src: TOP_FIXED, fix_bits: FULL_BITS, upd: UPD_NOW,
                ovf: OVF_AT_MAX, dual: 1'b0, fast: 1'b0, hold: 1'b0};
        case (mode)
            4'd0: ;
            4'd1, 4'd2, 4'd3: begin
                cfg.fix_bits = 5'd7 + 5'(mode);
                cfg.upd      = UPD_AT_TOP;
                cfg.ovf      = OVF_AT_BOT;
                cfg.dual     = 1'b1;
            end
            4'd4: cfg.src = TOP_CMPA;
            4'd5, 4'd6, 4'd7: begin
                cfg.fix_bits = 5'(mode) + 5'd3;
                cfg.upd      = UPD_AT_BOT;
                cfg.ovf      = OVF_AT_TOP;
                cfg.fast     = 1'b1;
            end
            4'd8, 4'd9, 4'd10, 4'd11: begin
                cfg.src  = mode[0] ? TOP_CMPA : TOP_CAPT;
                cfg.upd  = mode[1] ? UPD_AT_TOP : UPD_AT_BOT;
                cfg.ovf  = OVF_AT_BOT;
                cfg.dual = 1'b1;
            end
            4'd12: cfg.src = TOP_CAPT;
            4'd13: begin
                cfg.upd  = UPD_NONE;
                cfg.ovf  = OVF_NONE;
                cfg.hold = 1'b1;
            end
            default: begin
                cfg.src  = mode[0] ? TOP_CMPA : TOP_CAPT;
                cfg.upd  = UPD_AT_BOT;
                cfg.ovf  = OVF_AT_TOP;
                cfg.fast = 1'b1;
            end
        endcase
    end

    // Purpose: pick TOP from the fixed width, compare A or the capture register.
    always_comb begin
        fixed_wide = (ONE << cfg.fix_bits) - ONE;
        case (cfg.src)
            TOP_CMPA: top = cmpa_act;
            TOP_CAPT: top = capt;
            default:  top = (32'(cfg.fix_bits) >= CNT_W) ? '1 : fixed_wide[CNT_W-1:0];
        endcase
    end

endmodule

// File: rtl/pwm16_counter.sv
// Up or up/down counter with TOP and BOTTOM event detection.
// Assumes events are judged on the value held during the enabled cycle.
module pwm16_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             dual,
    input  logic             hold,
    input  logic [CNT_W-1:0] top,
    output logic [CNT_W-1:0] cnt,
    output logic             dir_down,
    output logic             ev_top,
    output logic             ev_bot,
    output logic             ev_max
);

    logic [CNT_W-1:0] cnt_q;
    logic             dir_q;
    logic             run;
    logic             at_top;
    logic             at_zero;

    // Purpose: decode the TOP, BOTTOM and MAX events of the current tick.
    always_comb begin
        run     = tick && !hold;
        at_zero = (cnt_q == '0);
        at_top  = (cnt_q >= top) && !(dual && dir_q);
        ev_top  = run && at_top;
        ev_bot  = run && (dual ? (dir_q && at_zero) : at_top);
        ev_max  = run && !dual && (cnt_q == '1);
    end

    // Purpose: advance the count and direction on each enabled tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            dir_q <= 1'b0;
        end else if (run) begin
            if (!dual) begin
                dir_q <= 1'b0;
                cnt_q <= at_top ? '0 : cnt_q + 1'b1;
            end else if (!dir_q) begin
                if (at_top) begin
                    dir_q <= 1'b1;
                    cnt_q <= at_zero ? '0 : cnt_q - 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else if (at_zero) begin
                dir_q <= 1'b0;
                cnt_q <= (top == '0) ? '0 : {{(CNT_W-1){1'b0}}, 1'b1};
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign cnt      = cnt_q;
    assign dir_down = dir_q;

endmodule

// File: rtl/pwm16_cmp_reg.sv
// One compare channel register pair: a shadow written by software and an
// active copy used by the comparator.
// Assumes imm and upd_ev are never high together (the mode table ensures it).
module pwm16_cmp_reg #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CNT_W-1:0] wdata,
    input  logic             imm,
    input  logic             upd_ev,
    output logic [CNT_W-1:0] act
);

    logic [CNT_W-1:0] shadow_q;
    logic [CNT_W-1:0] act_q;

    // Purpose: capture writes in the shadow and load the active copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
            act_q    <= '0;
        end else begin
            if (we) shadow_q <= wdata;
            if (we && imm)   act_q <= wdata;
            else if (upd_ev) act_q <= shadow_q;
        end
    end

    assign act = act_q;

endmodule

// File: rtl/pwm16_wave_out.sv
// PWM output stage of one channel for fast and dual-slope shapes.
// Assumes match is already gated with the tick and the reserved mode.
module pwm16_wave_out (
    input  logic clk,
    input  logic rst_n,
    input  logic fast,
    input  logic dual,
    input  logic ev_top,
    input  logic match,
    input  logic dir_down,
    output logic pwm
);

    logic pwm_q;

    // Purpose: set/clear the output at the points the active shape defines.
    always_ff @(posedge clk) begin
        if (!rst_n)             pwm_q <= 1'b0;
        else if (!fast && !dual) pwm_q <= 1'b0;
        else if (fast) begin
            if (ev_top)     pwm_q <= 1'b1;
            else if (match) pwm_q <= 1'b0;
        end else if (match) pwm_q <= dir_down;
    end

    assign pwm = pwm_q;

endmodule

// File: rtl/pwm16_timer.sv
// Top of the multi-mode PWM timer: mode register, capture register,
// compare channels, counter, output stages and sticky flags.
// Assumes tick is a single-cycle enable from an external prescaler.
module pwm16_timer
    import pwm16_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_wd,
    input  logic              ocra_we,
    input  logic              ocrb_we,
    input  logic              cap_we,
    input  logic [CNT_W-1:0]  wdata,
    input  logic [NFLAG-1:0]  flag_clr,
    output logic [CNT_W-1:0]  count,
    output logic              pwm_a,
    output logic              pwm_b,
    output logic              ovf_flag,
    output logic              cmpa_flag,
    output logic              cmpb_flag
);

    logic [MODE_W-1:0] mode_q;
    logic [CNT_W-1:0]  capt_q;
    mode_cfg_t         cfg;
    logic [CNT_W-1:0]  top;
    logic [CNT_W-1:0]  cnt;
    logic              dir_down;
    logic              ev_top, ev_bot, ev_max;
    logic              upd_ev, ovf_ev;
    logic [NCMP-1:0]   wr;
    logic [NCMP-1:0]   match;
    logic [NCMP-1:0]   pwm;
    logic [CNT_W-1:0]  act [NCMP];
    logic [NFLAG-1:0]  flags_q;

    // Purpose: hold the mode code and the capture register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            capt_q <= '0;
        end else begin
            if (mode_we) mode_q <= mode_wd;
            if (cap_we)  capt_q <= wdata;
        end
    end

    pwm16_mode_decode #(.CNT_W(CNT_W)) dec_i (
        .mode     (mode_q),
        .cmpa_act (act[0]),
        .capt     (capt_q),
        .cfg      (cfg),
        .top      (top)
    );

    pwm16_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .dual     (cfg.dual),
        .hold     (cfg.hold),
        .top      (top),
        .cnt      (cnt),
        .dir_down (dir_down),
        .ev_top   (ev_top),
        .ev_bot   (ev_bot),
        .ev_max   (ev_max)
    );

    // Purpose: choose the buffer update and overflow points of the mode.
    always_comb begin
        upd_ev = (cfg.upd == UPD_AT_TOP && ev_top) || (cfg.upd == UPD_AT_BOT && ev_bot);
        case (cfg.ovf)
            OVF_AT_MAX: ovf_ev = ev_max;
            OVF_AT_TOP: ovf_ev = ev_top;
            OVF_AT_BOT: ovf_ev = ev_bot;
            default:    ovf_ev = 1'b0;
        endcase
    end

    assign wr = {ocrb_we, ocra_we};

    for (genvar ch = 0; ch < NCMP; ch++) begin : g_ch
        pwm16_cmp_reg #(.CNT_W(CNT_W)) reg_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .we     (wr[ch]),
            .wdata  (wdata),
            .imm    (cfg.upd == UPD_NOW),
            .upd_ev (upd_ev),
            .act    (act[ch])
        );

        assign match[ch] = tick && !cfg.hold && (cnt == act[ch]);

        pwm16_wave_out out_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .fast     (cfg.fast),
            .dual     (cfg.dual),
            .ev_top   (ev_top),
            .match    (match[ch]),
            .dir_down (dir_down),
            .pwm      (pwm[ch])
        );
    end

    // Purpose: sticky flags, a set event wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~flag_clr) | {match, ovf_ev};
    end

    assign count     = cnt;
    assign pwm_a     = pwm[0];
    assign pwm_b     = pwm[1];
    assign ovf_flag  = flags_q[0];
    assign cmpa_flag = flags_q[1];
    assign cmpb_flag = flags_q[2];

endmodule

// File: rtl/pwm16_timer_chk.sv
// Assertion checker for pwm16_timer, attached by bind below.
// Assumes mode_r is the registered mode code inside the top.
module pwm16_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic [2:0]       flag_clr,
    input logic [CNT_W-1:0] count,
    input logic             pwm_a,
    input logic             pwm_b,
    input logic             ovf_flag,
    input logic             cmpa_flag,
    input logic             cmpb_flag,
    input logic [3:0]       mode_r
);

    function automatic logic quiet_mode(input logic [3:0] m);
        return (m == 4'd0) || (m == 4'd4) || (m == 4'd12) || (m == 4'd13);
    endfunction

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count));

    p_reserved_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mode_r == 4'd13) |=> $stable(count));

    p_ovf_needs_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> $past(tick));

    p_cmpa_needs_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmpa_flag) |-> $past(tick));

    p_cmpb_needs_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmpb_flag) |-> $past(tick));

    p_ovf_clear_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr[0] && !tick) |=> !ovf_flag);

    p_cmpa_clear_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr[1] && !tick) |=> !cmpa_flag);

    p_cmpb_clear_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr[2] && !tick) |=> !cmpb_flag);

    p_quiet_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet_mode(mode_r) && quiet_mode($past(mode_r))) |-> (!pwm_a && !pwm_b));

endmodule

bind pwm16_timer pwm16_timer_chk #(.CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .flag_clr  (flag_clr),
    .count     (count),
    .pwm_a     (pwm_a),
    .pwm_b     (pwm_b),
    .ovf_flag  (ovf_flag),
    .cmpa_flag (cmpa_flag),
    .cmpb_flag (cmpb_flag),
    .mode_r    (mode_q)
);

// File: tb/pwm16_timer_tb.sv
// Bench for pwm16_timer: random stimulus per mode against a requirement model.
module pwm16_timer_tb_top;

    localparam int CLK_P = 10;
    localparam int SEED  = 1234;

    logic        clk = 1'b0;
    logic        rst_n, tick, mode_we, ocra_we, ocrb_we, cap_we;
    logic [3:0]  mode_wd;
    logic [15:0] wdata;
    logic [2:0]  flag_clr;
    logic [15:0] count;
    logic        pwm_a, pwm_b, ovf_flag, cmpa_flag, cmpb_flag;

    int n_chk = 0, n_fail = 0;
    logic done = 1'b0;
    logic [15:0] peak;

    always #(CLK_P/2) clk = ~clk;

    pwm16_timer dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode_we(mode_we), .mode_wd(mode_wd),
        .ocra_we(ocra_we), .ocrb_we(ocrb_we), .cap_we(cap_we), .wdata(wdata),
        .flag_clr(flag_clr), .count(count), .pwm_a(pwm_a), .pwm_b(pwm_b),
        .ovf_flag(ovf_flag), .cmpa_flag(cmpa_flag), .cmpb_flag(cmpb_flag)
    );

    // ---------------- requirement model ----------------
    function automatic logic is_dual(input logic [3:0] m);
        return m inside {4'd1, 4'd2, 4'd3, 4'd8, 4'd9, 4'd10, 4'd11};
    endfunction
    function automatic logic is_fast(input logic [3:0] m);
        return m inside {4'd5, 4'd6, 4'd7, 4'd14, 4'd15};
    endfunction
    function automatic logic is_imm(input logic [3:0] m);
        return m inside {4'd0, 4'd4, 4'd12};
    endfunction
    function automatic logic upd_at_top(input logic [3:0] m);
        return m inside {4'd1, 4'd2, 4'd3, 4'd10, 4'd11};
    endfunction
    function automatic logic upd_at_bot(input logic [3:0] m);
        return is_fast(m) || m == 4'd8 || m == 4'd9;
    endfunction
    function automatic logic [15:0] exp_top(input logic [3:0] m, input logic [15:0] a,
                                            input logic [15:0] c);
        case (m)
            4'd0:                      return 16'hFFFF;
            4'd1, 4'd5:                return 16'h00FF;
            4'd2, 4'd6:                return 16'h01FF;
            4'd3, 4'd7:                return 16'h03FF;
            4'd4, 4'd9, 4'd11, 4'd15:  return a;
            4'd8, 4'd10, 4'd12, 4'd14: return c;
            default:                   return 16'h0000;
        endcase
    endfunction

    logic [3:0]  m_mode;
    logic [15:0] m_cnt, m_icr, t;
    logic        m_dir, run, dl, e_top, e_bot, e_max, ovf, upd;
    logic [15:0] m_sh [2];
    logic [15:0] m_ac [2];
    logic [1:0]  mt, m_pwm;
    logic [2:0]  m_fl, m_clr_last;

    // Purpose: advance the model one clock from the same inputs the design sees.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_cnt = 0; m_dir = 0; m_icr = 0; m_fl = 0; m_pwm = 0;
            m_clr_last = 0;
            for (int c = 0; c < 2; c++) begin m_sh[c] = 0; m_ac[c] = 0; end
        end else begin
            t   = exp_top(m_mode, m_ac[0], m_icr);
            run = tick && (m_mode != 4'd13);
            dl  = is_dual(m_mode);
            if (dl) begin
                e_top = run && !m_dir && m_cnt >= t;
                e_bot = run && m_dir && m_cnt == 0;
            end else begin
                e_top = run && m_cnt >= t;
                e_bot = e_top;
            end
            e_max = run && !dl && m_cnt == 16'hFFFF;
            for (int c = 0; c < 2; c++) mt[c] = run && m_cnt == m_ac[c];
            ovf = (is_imm(m_mode) && e_max) || (is_fast(m_mode) && e_top) || (dl && e_bot);
            upd = (upd_at_top(m_mode) && e_top) || (upd_at_bot(m_mode) && e_bot);
            m_fl = (m_fl & ~flag_clr) | {mt, ovf};
            for (int c = 0; c < 2; c++) begin
                if (!is_fast(m_mode) && !dl) m_pwm[c] = 1'b0;
                else if (is_fast(m_mode)) begin
                    if (e_top) m_pwm[c] = 1'b1;
                    else if (mt[c]) m_pwm[c] = 1'b0;
                end else if (mt[c]) m_pwm[c] = m_dir;
            end
            for (int c = 0; c < 2; c++) begin
                if ((c == 0 ? ocra_we : ocrb_we) && is_imm(m_mode)) m_ac[c] = wdata;
                else if (upd) m_ac[c] = m_sh[c];
                if (c == 0 ? ocra_we : ocrb_we) m_sh[c] = wdata;
            end
            if (cap_we) m_icr = wdata;
            if (run) begin
                if (!dl) begin
                    m_dir = 0;
                    m_cnt = (m_cnt >= t) ? 16'd0 : m_cnt + 16'd1;
                end else if (!m_dir) begin
                    if (m_cnt >= t) begin
                        m_dir = 1;
                        m_cnt = (m_cnt == 0) ? 16'd0 : m_cnt - 16'd1;
                    end else m_cnt = m_cnt + 16'd1;
                end else if (m_cnt == 0) begin
                    m_dir = 0;
                    m_cnt = (t == 0) ? 16'd0 : 16'd1;
                end else m_cnt = m_cnt - 16'd1;
            end
            if (mode_we) m_mode = mode_wd;
            m_clr_last = flag_clr;
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input string tag, input string what, input logic [15:0] act,
                       input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        string ct, at, pt;
        ct = (m_mode == 4'd13) ? "R12" : is_dual(m_mode) ? "R4" : "R2";
        chk(ct, "count", count, m_cnt);
        chk(m_clr_last[0] ? "R13" : "R7", "ovf_flag", 16'(ovf_flag), 16'(m_fl[0]));
        at = m_clr_last[1] ? "R13" : (m_mode == 4'd13) ? "R12" : is_imm(m_mode) ? "R5" : "R6";
        chk(at, "cmpa_flag", 16'(cmpa_flag), 16'(m_fl[1]));
        chk(m_clr_last[2] ? "R13" : "R8", "cmpb_flag", 16'(cmpb_flag), 16'(m_fl[2]));
        pt = is_fast(m_mode) ? "R9" : is_dual(m_mode) ? "R10" : "R11";
        chk(pt, "pwm_a", 16'(pwm_a), 16'(m_pwm[0]));
        chk(pt, "pwm_b", 16'(pwm_b), 16'(m_pwm[1]));
    endtask

    task automatic cycle();
        @(negedge clk);
        if (rst_n) begin
            compare_all();
            if (count > peak) peak = count;
        end
    endtask

    task automatic idle_inputs();
        tick = 0; mode_we = 0; ocra_we = 0; ocrb_we = 0; cap_we = 0;
        mode_wd = 0; wdata = 0; flag_clr = 0;
    endtask

    task automatic do_reset();
        idle_inputs();
        rst_n = 0;
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        chk("R1", "reset count", count, 16'h0);
        chk("R1", "reset flags", 16'({ovf_flag, cmpa_flag, cmpb_flag}), 16'h0);
        chk("R1", "reset pwm", 16'({pwm_a, pwm_b}), 16'h0);
        peak = 0;
    endtask

    task automatic wr_reg(input int which, input logic [15:0] v);
        idle_inputs();
        wdata = v;
        case (which)
            0: ocra_we = 1;
            1: ocrb_we = 1;
            2: cap_we  = 1;
            default: begin mode_we = 1; mode_wd = v[3:0]; end
        endcase
        cycle();
        idle_inputs();
    endtask

    task automatic run_mode(input logic [3:0] m, input int n);
        do_reset();
        wr_reg(3, 16'(m));
        wr_reg(2, 16'(8 + $urandom % 53));
        wr_reg(0, 16'(4 + $urandom % 37));
        wr_reg(1, 16'($urandom % 46));
        for (int i = 0; i < n; i++) begin
            tick = ($urandom % 4) != 0;
            {ocra_we, ocrb_we, cap_we} = 3'b000;
            if ($urandom % 48 == 0) begin
                wdata = 16'(2 + $urandom % 44);
                case ($urandom % 3)
                    0: ocra_we = 1;
                    1: ocrb_we = 1;
                    default: cap_we = 1;
                endcase
            end
            flag_clr = ($urandom % 6 == 0) ? 3'($urandom % 8) : 3'b000;
            cycle();
        end
        idle_inputs();
    endtask

    task automatic run_peak(input logic [3:0] m, input logic [15:0] capt,
                            input logic [15:0] cmpa, input int n, input logic [15:0] exp);
        do_reset();
        wr_reg(3, 16'(m));
        wr_reg(2, capt);
        wr_reg(0, cmpa);
        tick = 1;
        for (int i = 0; i < n; i++) cycle();
        tick = 0;
        chk("R3", "peak count", peak, exp);
    endtask

    initial begin
        void'($urandom(SEED));
        idle_inputs();
        rst_n = 0;
        for (int m = 0; m < 16; m++) run_mode(4'(m), 3000);
        run_peak(4'd6, 16'd0, 16'd0, 1100, 16'h01FF);
        run_peak(4'd14, 16'd37, 16'd5, 200, 16'd37);
        run_peak(4'd11, 16'd0, 16'd21, 200, 16'd21);
        run_peak(4'd0, 16'd0, 16'd9, 65600, 16'hFFFF);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_P * 195000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R2 watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule